// File: doc/BRIEF.md
# Virtually Indexed Physically Tagged L1 Data Lookup

This block is the lookup path of a level-one data cache. It holds 64-byte lines in 64 sets of 8 ways, 32 KB in all. A 4 KB page leaves the low 12 address bits untranslated. Those bits hold both the set index and the offset within the line. The set read can therefore start from the virtual address while the page number is still being translated. The physical page number arrives one cycle after the request. It is compared with the physical tags that were read out, and the result, the way and the selected data word follow one cycle later.

A request carries only the word address inside the page. The page number goes to an external translator, and its result returns on the translation pins in the cycle after the request is accepted. On a miss the block requests the physical line from the next level. While that fill is outstanding it accepts no new lookups. When the line returns, it is written into the first empty way, or into the way chosen by a tree pseudo-LRU. The requester retries after a miss.

The lookup and both fill channels are valid/ready. A transfer happens on an edge where both are high. A valid, once raised, stays high with its payload unchanged until it is accepted. The result pulse has no back-pressure: it always appears exactly two edges after acceptance.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset, lk_ready is 1 and rs_valid, fq_valid and fd_ready are 0. All ways are empty, so the first lookup of any set misses.
- R2: A lookup accepted on edge k takes its translation from the cycle between edges k and k+1. Exactly one rs_valid pulse for it appears after edge k+1.
- R3: The set is bits [8:3] of lk_word_off and the word within the line is bits [2:0]. The lookup hits when a filled way of that set holds a tag equal to xl_ppn. Then rs_hit=1, rs_way is that way, and rs_data is the 64-bit word taken from bits [64*w +: 64] of the stored line.
- R4: If xl_valid is 0 or xl_fault is 1 in the translation cycle, the result has rs_abort=1 and rs_hit=0. No fill is requested and the replacement state does not change.
- R5: On a miss, rs_hit=0 and rs_abort=0. From the same edge, fq_valid is raised with fq_line_addr = {xl_ppn, set}, and it is held stable until fq_ready.
- R6: After the request handshake, fd_ready stays 1 until fd_valid. The line is then written, and later hits return its words. lk_ready is 0 from the missing lookup's translation cycle until the line is written.
- R7: If the set has an empty way, the lowest-numbered empty way is filled, and rs_way of the miss names it.
- R8: In a full set the victim comes from the 7-bit tree. Start at node 0. At each node, bit 0 means go to the lower half and bit 1 the upper half. Node n leads to children 2n+1 and 2n+2. The leaf reached, minus 7, is the way.
- R9: With no fill pending, lk_ready is 1 in a translation cycle whose lookup hits or aborts. Lookups therefore flow at one per cycle.
- R10: A hit, and a completed fill, update the tree along that way's path. Each node on the path is set to point away from the way that was used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with lk_valid |
| lk_word_off | input | 9 | Word address within the page: set in [8:3], word in [2:0] |
| xl_valid | input | 1 | Translation present in the cycle after acceptance |
| xl_fault | input | 1 | Translation reports a fault |
| xl_ppn | input | PPN_W (40) | Translated physical page number |
| rs_valid | output | 1 | Result pulse |
| rs_hit | output | 1 | Lookup hit |
| rs_abort | output | 1 | Lookup cancelled by translation |
| rs_way | output | 3 | Hit way, or the way chosen for the fill on a miss |
| rs_data | output | 64 | Selected word on a hit, zero otherwise |
| fq_valid | output | 1 | Fill request valid |
| fq_ready | input | 1 | Fill request accepted |
| fq_line_addr | output | PPN_W+6 (46) | Physical line address of the fill |
| fd_valid | input | 1 | Fill line valid |
| fd_ready | output | 1 | Block waits for the fill line |
| fd_line | input | 512 | Fill line, word w at [64*w +: 64] |

## Verification
The bench builds the block with an 8-bit tag and keeps the default split of 6 set bits, 6 line-offset bits and 8 ways. With a tag that short, a handful of page numbers can fill one set completely and then force victim choices from the pseudo-LRU tree. It can also reuse the same page number across sets. The memory stays small, while the index and offset arithmetic is exactly the one used at full tag width.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_REQ  = 2'd1,
    FILL_WAIT = 2'd2
  } fill_state_e;
endpackage

// File: rtl/vipt_way_ram.sv
module vipt_way_ram #(
  parameter int TAG_W     = 40,
  parameter int SET_W     = 6,
  parameter int LINE_BITS = 512
) (
  input  logic                 clk,
  input  logic                 rd_en,
  input  logic [SET_W-1:0]     rd_set,
  input  logic                 wr_en,
  input  logic [SET_W-1:0]     wr_set,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic [LINE_BITS-1:0] wr_line,
  output logic [TAG_W-1:0]     rd_tag,
  output logic [LINE_BITS-1:0] rd_line
);
  localparam int SETS = 1 << SET_W;

  logic [TAG_W-1:0]     tag_mem  [SETS];
  logic [LINE_BITS-1:0] line_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set]  <= wr_tag;
      line_mem[wr_set] <= wr_line;
    end
    if (rd_en) begin
      rd_tag  <= tag_mem[rd_set];
      rd_line <= line_mem[rd_set];
    end
  end
endmodule

// File: rtl/vipt_repl.sv
module vipt_repl #(
  parameter int WAYS  = 8,
  parameter int SET_W = 6,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] look_set,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  output logic [WAYS-1:0]  look_valid,
  output logic [WAY_W-1:0] victim
);
  localparam int SETS = 1 << SET_W;

  logic [WAYS-2:0] tree_q [SETS];
  logic [WAYS-1:0] vld_q  [SETS];
  logic [WAYS-2:0] tree_next;
  logic [WAY_W-1:0] tree_way;

  // path update: each node on the way's path points away from it
  always_comb begin
    int n;
    logic dir;
    tree_next = tree_q[touch_set];
    n = 0;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      dir = touch_way[WAY_W-1-lvl];
      tree_next[n] = ~dir;
      n = 2 * n + 1 + int'(dir);
    end
  end

  // victim: lowest empty way, else walk the tree
  always_comb begin
    int n;
    logic found;
    n = 0;
    for (int lvl = 0; lvl < WAY_W; lvl++)
      n = 2 * n + 1 + int'(tree_q[look_set][n]);
    tree_way = WAY_W'(n - (WAYS - 1));
    victim = tree_way;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vld_q[look_set][w] && !found) begin
        victim = WAY_W'(w);
        found = 1'b1;
      end
    end
  end

  assign look_valid = vld_q[look_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tree_q[s] <= '0;
        vld_q[s]  <= '0;
      end
    end else begin
      if (touch_en) tree_q[touch_set] <= tree_next;
      if (fill_en)  vld_q[fill_set][fill_way] <= 1'b1;
    end
  end

  AST_EMPTY_WAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (look_valid != '1) |-> !look_valid[victim]); // R7
endmodule

// File: rtl/vipt_tag_cmp.sv
module vipt_tag_cmp #(
  parameter int WAYS      = 8,
  parameter int TAG_W     = 40,
  parameter int LINE_BITS = 512,
  parameter int WORD_W    = 64,
  parameter int WSEL_W    = 3,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0]     tags,
  input  logic [WAYS-1:0][LINE_BITS-1:0] lines,
  input  logic [WAYS-1:0]                way_valid,
  input  logic [TAG_W-1:0]               ppn,
  input  logic [WSEL_W-1:0]              word_sel,
  output logic [WAYS-1:0]                match,
  output logic                           hit,
  output logic [WAY_W-1:0]               hit_way,
  output logic [WORD_W-1:0]              hit_word
);
  logic [LINE_BITS-1:0] sel_line;

  always_comb begin
    hit_way  = '0;
    sel_line = '0;
    for (int w = 0; w < WAYS; w++) begin
      match[w] = way_valid[w] && (tags[w] == ppn);
      if (match[w]) begin
        hit_way  = WAY_W'(w);
        sel_line = lines[w];
      end
    end
    hit      = |match;
    hit_word = sel_line[word_sel*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
  import vipt_pkg::*;
#(
  parameter int PPN_W  = 40,
  parameter int WAYS   = 8,
  parameter int SET_W  = 6,
  parameter int OFF_W  = 6,
  parameter int WORD_W = 64,
  localparam int WB_W      = $clog2(WORD_W / 8),
  localparam int WSEL_W    = OFF_W - WB_W,
  localparam int IN_W      = SET_W + WSEL_W,
  localparam int LINE_BITS = (1 << OFF_W) * 8,
  localparam int WAY_W     = $clog2(WAYS),
  localparam int FQ_W      = PPN_W + SET_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  output logic                 lk_ready,
  input  logic [IN_W-1:0]      lk_word_off,
  input  logic                 xl_valid,
  input  logic                 xl_fault,
  input  logic [PPN_W-1:0]     xl_ppn,
  output logic                 rs_valid,
  output logic                 rs_hit,
  output logic                 rs_abort,
  output logic [WAY_W-1:0]     rs_way,
  output logic [WORD_W-1:0]    rs_data,
  output logic                 fq_valid,
  input  logic                 fq_ready,
  output logic [FQ_W-1:0]      fq_line_addr,
  input  logic                 fd_valid,
  output logic                 fd_ready,
  input  logic [LINE_BITS-1:0] fd_line
);
  fill_state_e fs_q;

  logic              s2_valid;
  logic [SET_W-1:0]  s2_set;
  logic [WSEL_W-1:0] s2_wsel;
  logic [SET_W-1:0]  f_set;
  logic [PPN_W-1:0]  f_tag;
  logic [WAY_W-1:0]  f_way;

  logic [WAYS-1:0][PPN_W-1:0]     rd_tags;
  logic [WAYS-1:0][LINE_BITS-1:0] rd_lines;
  logic [WAYS-1:0] set_valid, match;
  logic [WAY_W-1:0] victim, hit_way;
  logic [WORD_W-1:0] hit_word;
  logic cmp_hit;

  // stage 1: untranslated index drives the set read
  wire accept    = lk_valid && lk_ready;
  wire xl_ok     = xl_valid && !xl_fault;
  wire s2_hit    = s2_valid && xl_ok && cmp_hit;
  wire s2_miss   = s2_valid && xl_ok && !cmp_hit;
  wire s2_abort  = s2_valid && !xl_ok;
  wire fill_fire = (fs_q == FILL_WAIT) && fd_valid;

  assign lk_ready     = (fs_q == FILL_IDLE) && !s2_miss;
  assign fq_valid     = (fs_q == FILL_REQ);
  assign fd_ready     = (fs_q == FILL_WAIT);
  assign fq_line_addr = {f_tag, f_set};

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    vipt_way_ram #(.TAG_W(PPN_W), .SET_W(SET_W), .LINE_BITS(LINE_BITS)) u_ram (
      .clk     (clk),
      .rd_en   (accept),
      .rd_set  (lk_word_off[IN_W-1:WSEL_W]),
      .wr_en   (fill_fire && (f_way == WAY_W'(g))),
      .wr_set  (f_set),
      .wr_tag  (f_tag),
      .wr_line (fd_line),
      .rd_tag  (rd_tags[g]),
      .rd_line (rd_lines[g])
    );
  end

  // stage 2: physical tag check against the late page number
  vipt_tag_cmp #(.WAYS(WAYS), .TAG_W(PPN_W), .LINE_BITS(LINE_BITS),
                 .WORD_W(WORD_W), .WSEL_W(WSEL_W)) u_cmp (
    .tags      (rd_tags),
    .lines     (rd_lines),
    .way_valid (set_valid),
    .ppn       (xl_ppn),
    .word_sel  (s2_wsel),
    .match     (match),
    .hit       (cmp_hit),
    .hit_way   (hit_way),
    .hit_word  (hit_word)
  );

  vipt_repl #(.WAYS(WAYS), .SET_W(SET_W)) u_repl (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_set   (s2_set),
    .touch_en   (s2_hit || fill_fire),
    .touch_set  (fill_fire ? f_set : s2_set),
    .touch_way  (fill_fire ? f_way : hit_way),
    .fill_en    (fill_fire),
    .fill_set   (f_set),
    .fill_way   (f_way),
    .look_valid (set_valid),
    .victim     (victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_set   <= '0;
      s2_wsel  <= '0;
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_abort <= 1'b0;
      rs_way   <= '0;
      rs_data  <= '0;
      fs_q     <= FILL_IDLE;
      f_set    <= '0;
      f_tag    <= '0;
      f_way    <= '0;
    end else begin
      s2_valid <= accept;
      if (accept) begin
        s2_set  <= lk_word_off[IN_W-1:WSEL_W];
        s2_wsel <= lk_word_off[WSEL_W-1:0];
      end
      rs_valid <= s2_valid;
      rs_hit   <= s2_hit;
      rs_abort <= s2_abort;
      rs_way   <= s2_hit ? hit_way : (s2_miss ? victim : '0);
      rs_data  <= s2_hit ? hit_word : '0;
      unique case (fs_q)
        FILL_IDLE: if (s2_miss) begin
          fs_q  <= FILL_REQ;
          f_set <= s2_set;
          f_tag <= xl_ppn;
          f_way <= victim;
        end
        FILL_REQ:  if (fq_ready) fs_q <= FILL_WAIT;
        FILL_WAIT: if (fd_valid) fs_q <= FILL_IDLE;
        default:   fs_q <= FILL_IDLE;
      endcase
    end
  end

  AST_RESULT_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lk_valid && lk_ready, 2) |-> rs_valid); // R2
  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |-> $onehot0(match)); // R3
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_abort) |-> (!fq_valid && !fd_ready && !rs_hit)); // R4
  AST_MISS_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit && !rs_abort) |-> fq_valid); // R5
  AST_FILL_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fq_valid && !fq_ready) |=> (fq_valid && $stable(fq_line_addr))); // R5
  AST_WAIT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fq_valid && fq_ready) |=> (fd_ready && !lk_ready)); // R6
endmodule

// File: tb/test_vipt_l1_lookup.sv
module test_vipt_l1_lookup;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic lk_ready;
  logic [8:0] lk_word_off = '0;
  logic xl_valid = 1'b0, xl_fault = 1'b0;
  logic [PW-1:0] xl_ppn = '0;
  logic rs_valid, rs_hit, rs_abort;
  logic [2:0] rs_way;
  logic [63:0] rs_data;
  logic fq_valid;
  logic fq_ready = 1'b0;
  logic [PW+5:0] fq_line_addr;
  logic fd_valid = 1'b0;
  logic fd_ready;
  logic [511:0] fd_line = '0;

  always #5 clk = ~clk;

  vipt_l1_lookup #(.PPN_W(PW)) i_vipt_l1_lookup (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_word_off(lk_word_off), .xl_valid(xl_valid), .xl_fault(xl_fault),
    .xl_ppn(xl_ppn), .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_abort(rs_abort),
    .rs_way(rs_way), .rs_data(rs_data), .fq_valid(fq_valid), .fq_ready(fq_ready),
    .fq_line_addr(fq_line_addr), .fd_valid(fd_valid), .fd_ready(fd_ready),
    .fd_line(fd_line)
  );

  int n_total = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [PW-1:0]  m_tag  [64][8];
  bit             m_vld  [64][8];
  logic [511:0]   m_line [64][8];
  bit             m_tree [64][7];
  int  m_state;            // 0 idle, 1 request, 2 wait
  bit  m_s2v;
  int  m_s2set, m_s2ws;
  int  f_set, f_way;
  logic [PW-1:0] f_tag;
  bit  e_rv, e_hit, e_abort;
  int  e_way;
  logic [63:0] e_data;
  string e_wlab;

  function automatic int tree_victim(int s);
    int n = 0;
    for (int l = 0; l < 3; l++) n = 2 * n + 1 + int'(m_tree[s][n]);
    return n - 7;
  endfunction

  function automatic void tree_touch(int s, int w);
    int n = 0;
    for (int l = 0; l < 3; l++) begin
      int d = (w >> (2 - l)) & 1;
      m_tree[s][n] = (d == 0);
      n = 2 * n + 1 + d;
    end
  endfunction

  // 0 hit, 1 miss, 2 abort; way returned through hw
  function automatic int outcome(output int hw);
    hw = 0;
    if (!xl_valid || xl_fault) return 2;
    for (int w = 0; w < 8; w++)
      if (m_vld[m_s2set][w] && m_tag[m_s2set][w] == xl_ppn) begin
        hw = w;
        return 0;
      end
    return 1;
  endfunction

  function automatic int pick_victim(int s, output bit from_empty);
    from_empty = 1'b1;
    for (int w = 0; w < 8; w++) if (!m_vld[s][w]) return w;
    from_empty = 1'b0;
    return tree_victim(s);
  endfunction

  function automatic bit exp_ready();
    int hw;
    if (m_state != 0) return 1'b0;
    if (m_s2v && outcome(hw) == 1) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 64; s++)
        for (int w = 0; w < 8; w++) begin
          m_vld[s][w] = 1'b0;
          if (w < 7) m_tree[s][w] = 1'b0;
        end
      m_state = 0; m_s2v = 0; e_rv = 0; e_hit = 0; e_abort = 0;
    end else begin
      bit rdy;
      int hw, oc;
      bit fe;
      rdy = exp_ready();
      e_rv = m_s2v; e_hit = 0; e_abort = 0;
      if (m_s2v) begin
        oc = outcome(hw);
        if (oc == 0) begin
          e_hit = 1; e_way = hw; e_wlab = "R3 R10";
          e_data = m_line[m_s2set][hw][m_s2ws*64 +: 64];
          tree_touch(m_s2set, hw);
        end else if (oc == 1) begin
          e_way = pick_victim(m_s2set, fe);
          e_wlab = fe ? "R7" : "R8 R10";
          m_state = 1; f_set = m_s2set; f_tag = xl_ppn; f_way = e_way;
        end else e_abort = 1;
      end else if (m_state == 1 && fq_ready) m_state = 2;
      else if (m_state == 2 && fd_valid) begin
        m_tag[f_set][f_way] = f_tag;
        m_vld[f_set][f_way] = 1'b1;
        m_line[f_set][f_way] = fd_line;
        tree_touch(f_set, f_way);
        m_state = 0;
      end
      m_s2v = lk_valid && rdy;
      if (m_s2v) begin
        m_s2set = int'(lk_word_off[8:3]);
        m_s2ws  = int'(lk_word_off[2:0]);
      end
    end
  end

  bit rdy_s = 1'b0;
  always @(negedge clk) begin
    rdy_s = lk_ready;
    if (rst_n && n_total > 0) begin
      bit er;
      er = exp_ready();
      chk(lk_ready == er, m_state != 0 ? "R6" : "R9", 64'(lk_ready), 64'(er));
      chk(rs_valid == e_rv, "R2", 64'(rs_valid), 64'(e_rv));
      if (e_rv) begin
        chk(rs_hit == e_hit, "R3", 64'(rs_hit), 64'(e_hit));
        chk(rs_abort == e_abort, "R4", 64'(rs_abort), 64'(e_abort));
        if (!e_abort) chk(int'(rs_way) == e_way, e_wlab, 64'(rs_way), 64'(e_way));
        if (e_hit) chk(rs_data == e_data, "R3 R6", rs_data, e_data);
      end
      chk(fq_valid == (m_state == 1), "R5", 64'(fq_valid), 64'(m_state == 1));
      if (m_state == 1)
        chk(fq_line_addr == {f_tag, 6'(f_set)}, "R5", 64'(fq_line_addr),
            64'({f_tag, 6'(f_set)}));
      chk(fd_ready == (m_state == 2), "R6", 64'(fd_ready), 64'(m_state == 2));
    end
  end

  // ---------------- fill responder ----------------
  initial begin
    int rst_st = 0, cnt = 0, seq = 0;
    logic [PW+5:0] addr = '0;
    forever begin
      @(posedge clk); #1;
      case (rst_st)
        0: if (rst_n && fq_valid) begin rst_st = 1; cnt = seq % 3; end
        1: if (cnt == 0) begin fq_ready = 1; addr = fq_line_addr; rst_st = 2; end
           else cnt--;
        2: begin fq_ready = 0; rst_st = 3; cnt = (seq + 1) % 3; end
        3: if (cnt == 0) begin
             for (int k = 0; k < 8; k++)
               fd_line[k*64 +: 64] = {32'(addr), 16'(seq), 16'(k)} ^ 64'h5a3c_96e1_0f27_b4d8;
             fd_valid = 1; rst_st = 4;
           end else cnt--;
        default: begin fd_valid = 0; rst_st = 0; seq++; end
      endcase
    end
  end

  // ---------------- stimulus ----------------
  typedef struct { int set; int ws; logic [PW-1:0] ppn; bit xv; bit xf; } req_t;
  req_t q[$];

  task automatic push(input int s, input int ws, input int p, input bit xv = 1,
                      input bit xf = 0);
    req_t r;
    r.set = s; r.ws = ws; r.ppn = PW'(p); r.xv = xv; r.xf = xf;
    q.push_back(r);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_total++;
    $display("FAIL R2 watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    int lcg = 7;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(lk_ready == 1'b1, "R1", 64'(lk_ready), 64'd1);
    chk(rs_valid == 1'b0, "R1", 64'(rs_valid), 64'd0);
    chk(fq_valid == 1'b0, "R1", 64'(fq_valid), 64'd0);
    chk(fd_ready == 1'b0, "R1", 64'(fd_ready), 64'd0);

    push(5, 2, 'h11);                 // first miss, empty way 0 (R7)
    push(5, 2, 'h11); push(5, 7, 'h11); // hits (R3, R6)
    for (int i = 0; i < 7; i++) begin // fill ways 1..7
      push(5, i, 'h20 + i);
      push(5, 7 - i, 'h20 + i);
    end
    push(5, 1, 'h11);                 // touch way 0 (R10)
    push(5, 3, 'h40); push(5, 3, 'h41); // tree victims (R8)
    push(5, 2, 'h20, 0, 0);           // R4 no translation, would hit
    push(5, 2, 'h21, 1, 1);           // R4 fault
    push(9, 0, 'h55, 1, 1);           // R4 fault on a miss
    push(5, 4, 'h42);                 // victim unaffected by aborts (R4, R8)
    push(9, 0, 'h11); push(63, 5, 'h11); push(0, 6, 'h11); // same page, other sets
    for (int i = 0; i < 6; i++) push(i % 2 ? 63 : 9, i, 'h11); // back to back (R9)
    push(5, 0, 'h40); push(5, 0, 'h41); push(5, 5, 'h42);
    for (int i = 0; i < 60; i++) begin
      int sets[4] = '{0, 5, 9, 63};
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      push(sets[(lcg >> 4) % 4], (lcg >> 8) % 8, 'h10 + ((lcg >> 12) % 12),
           ((lcg >> 20) % 9) != 0, ((lcg >> 24) % 11) == 0);
    end

    while (q.size() > 0 || lk_valid) begin
      bit acc;
      @(posedge clk);
      acc = lk_valid && rdy_s;
      #1;
      if (acc) begin
        req_t c;
        c = q.pop_front();
        xl_valid = c.xv; xl_fault = c.xf; xl_ppn = c.ppn;
      end else begin
        xl_valid = 0; xl_fault = 0; xl_ppn = '0;
      end
      if (q.size() > 0) begin
        lk_valid = 1;
        lk_word_off = {6'(q[0].set), 3'(q[0].ws)};
      end else lk_valid = 0;
    end
    @(posedge clk); #1;
    xl_valid = 0; xl_fault = 0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule